// File: doc/BRIEF.md
# Coherent Fabric Routing Table

This block is the per-node routing lookup of a small coherent multiprocessor fabric. The fabric has up to eight nodes, and each node has three outgoing links. The table holds one route entry for each destination node. Each entry has three 4-bit masks, one for each packet class: request, response and broadcast. A mask bit selects the local node or one of the three links. Request and response masks are returned exactly as stored. A broadcast mask may name several targets at once.

Software programs the table through a simple 32-bit register bus. The same bus holds a control word and a local node-ID register. The control word has three parts:
- a routing-disable bit, which forces every packet to a fixed default link;
- a request-disable bit, which gates whether the node may generate new requests;
- a read-only copy of the default link.

Each lookup takes a destination node and a packet class. One cycle later the block returns the delivery mask. With it comes a flag that says whether the destination is the node itself.

Top module: `cfab_route_table`

## Requirements
- R1: After reset every route entry reads 0x00010101, the control word reads with the routing-disable and request-disable bits both 1, and the node-ID register reads 0.
- R2: Route entry i sits at byte address 4*i (word index i, address bits [1:0] ignored). Its request mask is bits [3:0], its response mask is bits [11:8] and its broadcast mask is bits [19:16]. All other bits read as zero and ignore writes.
- R3: Mask bit 0 means the local node, bit 1 link 0, bit 2 link 1 and bit 3 link 2. With routing enabled, a lookup of class 0 (request), 1 (response) or 2 (broadcast) returns that class's field of the entry for the destination, unchanged, including masks with several bits set.
- R4: A lookup of class 3 with routing enabled returns an all-zero mask, while its valid output is still raised.
- R5: lk_valid_o is high exactly one cycle after lk_valid_i was high. lk_mask_o and lk_self_o are zero in any cycle where lk_valid_o is low.
- R6: A write to a route entry affects lookups presented in the following cycle and later. A lookup presented in the same cycle as the write sees the old value.
- R7: While routing-disable is 1, every lookup ignores the table and returns a one-hot mask from the default link code: 00 gives bit 1, 01 gives bit 2, 10 gives bit 3 and 11 gives bit 0. The default code is the parameter DEF_LINK, which defaults to 11.
- R8: The control word is at byte address 4*NODES (0x20 by default). Bit 0 is routing-disable and bit 1 is request-disable, and both are writable. Bits [3:2] read the default link code and ignore writes. All other bits read zero.
- R9: req_gen_en_o is 1 exactly when the request-disable bit is 0.
- R10: The node-ID register is at byte address 4*NODES+4 (0x24 by default), with the ID in bits [2:0] and all other bits read zero. lk_self_o is 1 on a valid lookup result whose destination equalled the node ID at presentation time.
- R11: Accesses to any other word address read zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| lk_valid_i | input | 1 | Lookup request valid |
| lk_dest_i | input | 3 | Destination node ID |
| lk_class_i | input | 2 | Packet class: 0 request, 1 response, 2 broadcast, 3 reserved |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_mask_o | output | 4 | Delivery mask: bit 0 local, bits 1..3 links 0..2 |
| lk_self_o | output | 1 | Destination equals the local node ID |
| req_gen_en_o | output | 1 | Request generation allowed |

## Verification
The hardest case to reach from the ports is a write and a lookup to the same entry on the same clock edge. The bench drives both in one cycle and expects the old mask. It then repeats the lookup one cycle later and expects the new mask. Entries are written with all-ones in their unused bits to show that only the three route fields are kept. The routing-disable bit is turned on again after the table has been programmed, which shows that the programmed entries are really bypassed.

// File: rtl/cfab_rt_pkg.sv
package cfab_rt_pkg;
  localparam int unsigned RT_LINKS = 3;
  localparam int unsigned RT_FW    = RT_LINKS + 1;
  localparam int unsigned RT_REQ_LSB = 0;
  localparam int unsigned RT_RSP_LSB = 8;
  localparam int unsigned RT_BC_LSB  = 16;

  typedef enum logic [1:0] {
    PKT_REQ   = 2'd0,
    PKT_RSP   = 2'd1,
    PKT_BCAST = 2'd2,
    PKT_RSVD  = 2'd3
  } pkt_class_e;

  typedef struct packed {
    logic [RT_FW-1:0] bcast;
    logic [RT_FW-1:0] rsp;
    logic [RT_FW-1:0] req;
  } rt_entry_t;

  localparam rt_entry_t RT_ENTRY_RST = '{bcast: 4'b0001, rsp: 4'b0001, req: 4'b0001};

  function automatic logic [31:0] rt_pack(rt_entry_t e);
    logic [31:0] w;
    w = '0;
    w[RT_REQ_LSB +: RT_FW] = e.req;
    w[RT_RSP_LSB +: RT_FW] = e.rsp;
    w[RT_BC_LSB  +: RT_FW] = e.bcast;
    return w;
  endfunction

  function automatic rt_entry_t rt_unpack(logic [31:0] w);
    rt_entry_t e;
    e.req   = w[RT_REQ_LSB +: RT_FW];
    e.rsp   = w[RT_RSP_LSB +: RT_FW];
    e.bcast = w[RT_BC_LSB  +: RT_FW];
    return e;
  endfunction

  function automatic logic [RT_FW-1:0] rt_def_mask(logic [1:0] code);
    logic [RT_FW-1:0] m;
    m = '0;
    if (code == 2'b11) m[0] = 1'b1;
    else               m[code + 2'd1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cfab_rt_regs.sv
module cfab_rt_regs
  import cfab_rt_pkg::*;
#(
  parameter int unsigned NODES    = 8,
  parameter int unsigned AW       = 8,
  parameter logic [1:0]  DEF_LINK = 2'b11,
  localparam int unsigned NW      = $clog2(NODES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output rt_entry_t       entries_o [NODES],
  output logic            route_dis_o,
  output logic            req_dis_o,
  output logic [NW-1:0]   node_id_o
);
  localparam int unsigned IW = AW - 2;
  localparam logic [IW-1:0] CTRL_IDX = IW'(NODES);
  localparam logic [IW-1:0] NID_IDX  = IW'(NODES + 1);

  logic [IW-1:0] idx;
  assign idx = addr_i[AW-1:2];

  for (genvar g = 0; g < NODES; g++) begin : g_entry
    logic hit;
    assign hit = we_i && (idx == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  entries_o[g] <= RT_ENTRY_RST;
      else if (hit) entries_o[g] <= rt_unpack(wdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_dis_o <= 1'b1;
      req_dis_o   <= 1'b1;
      node_id_o   <= '0;
    end else if (we_i) begin
      if (idx == CTRL_IDX) begin
        route_dis_o <= wdata_i[0];
        req_dis_o   <= wdata_i[1];
      end
      if (idx == NID_IDX) node_id_o <= wdata_i[NW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx < CTRL_IDX) begin
      rdata_o = rt_pack(entries_o[idx[NW-1:0]]);
    end else if (idx == CTRL_IDX) begin
      rdata_o[0]   = route_dis_o;
      rdata_o[1]   = req_dis_o;
      rdata_o[3:2] = DEF_LINK;
    end else if (idx == NID_IDX) begin
      rdata_o[NW-1:0] = node_id_o;
    end
  end

  // R10: node-ID write lands one cycle later
  p_nid_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == NID_IDX) |=> node_id_o == $past(wdata_i[NW-1:0]));

  // R11: no write strobe, no table change
  p_entry_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(entries_o[0]) && $stable(entries_o[NODES-1]));
endmodule

// File: rtl/cfab_rt_lookup.sv
module cfab_rt_lookup
  import cfab_rt_pkg::*;
#(
  parameter int unsigned NODES = 8,
  localparam int unsigned NW   = $clog2(NODES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rt_entry_t        entries_i [NODES],
  input  logic             route_dis_i,
  input  logic [1:0]       def_link_i,
  input  logic [NW-1:0]    node_id_i,
  input  logic             lk_valid_i,
  input  logic [NW-1:0]    lk_dest_i,
  input  logic [1:0]       lk_class_i,
  output logic             lk_valid_o,
  output logic [RT_FW-1:0] lk_mask_o,
  output logic             lk_self_o
);
  rt_entry_t        sel;
  logic [RT_FW-1:0] mask_d;

  assign sel = entries_i[lk_dest_i];

  always_comb begin
    mask_d = '0;
    if (route_dis_i) begin
      mask_d = rt_def_mask(def_link_i);
    end else begin
      unique case (pkt_class_e'(lk_class_i))
        PKT_REQ:   mask_d = sel.req;
        PKT_RSP:   mask_d = sel.rsp;
        PKT_BCAST: mask_d = sel.bcast;
        default:   mask_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o <= 1'b0;
      lk_mask_o  <= '0;
      lk_self_o  <= 1'b0;
    end else begin
      lk_valid_o <= lk_valid_i;
      lk_mask_o  <= lk_valid_i ? mask_d : '0;
      lk_self_o  <= lk_valid_i && (lk_dest_i == node_id_i);
    end
  end

  p_valid_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_valid_o);

  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !lk_valid_o && lk_mask_o == '0 && !lk_self_o);

  p_default_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && route_dis_i) |=> $countones(lk_mask_o) == 1);

  p_rsvd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !route_dis_i && lk_class_i == 2'd3) |=> lk_mask_o == '0);
endmodule

// File: rtl/cfab_route_table.sv
module cfab_route_table
  import cfab_rt_pkg::*;
#(
  parameter int unsigned NODES    = 8,
  parameter int unsigned AW       = 8,
  parameter logic [1:0]  DEF_LINK = 2'b11,
  localparam int unsigned NW      = $clog2(NODES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             lk_valid_i,
  input  logic [NW-1:0]    lk_dest_i,
  input  logic [1:0]       lk_class_i,
  output logic             lk_valid_o,
  output logic [RT_FW-1:0] lk_mask_o,
  output logic             lk_self_o,
  output logic             req_gen_en_o
);
  rt_entry_t     entries [NODES];
  logic          route_dis;
  logic          req_dis;
  logic [NW-1:0] node_id;

  cfab_rt_regs #(.NODES(NODES), .AW(AW), .DEF_LINK(DEF_LINK)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .entries_o   (entries),
    .route_dis_o (route_dis),
    .req_dis_o   (req_dis),
    .node_id_o   (node_id)
  );

  cfab_rt_lookup #(.NODES(NODES)) u_lookup (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .entries_i   (entries),
    .route_dis_i (route_dis),
    .def_link_i  (DEF_LINK),
    .node_id_i   (node_id),
    .lk_valid_i  (lk_valid_i),
    .lk_dest_i   (lk_dest_i),
    .lk_class_i  (lk_class_i),
    .lk_valid_o  (lk_valid_o),
    .lk_mask_o   (lk_mask_o),
    .lk_self_o   (lk_self_o)
  );

  assign req_gen_en_o = !req_dis;

  // R9: request gate follows a control write one cycle later
  p_req_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i[AW-1:2] == (AW-2)'(NODES)) |=> req_gen_en_o == !$past(reg_wdata_i[1]));
endmodule

// File: tb/cfab_route_table_tb_top.sv
module cfab_route_table_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        lk_v = 1'b0;
  logic [2:0]  lk_dest = '0;
  logic [1:0]  lk_cls = '0;
  logic        lk_vo;
  logic [3:0]  lk_mask;
  logic        lk_self;
  logic        req_en;
  int          n_checks = 0;
  int          n_errors = 0;

  always #10 clk = ~clk;

  cfab_route_table dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .lk_valid_i(lk_v),
    .lk_dest_i(lk_dest), .lk_class_i(lk_cls), .lk_valid_o(lk_vo),
    .lk_mask_o(lk_mask), .lk_self_o(lk_self), .req_gen_en_o(req_en)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #2 d = rdata;
  endtask

  task automatic lookup(logic [2:0] dst, logic [1:0] c, output logic [5:0] res);
    @(negedge clk);
    lk_v = 1'b1; lk_dest = dst; lk_cls = c;
    @(negedge clk);
    lk_v = 1'b0;
    res = {lk_vo, lk_self, lk_mask};
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      reg_rd(8'(4*i), d);
      check("R1 entry reset", d, 32'h0001_0101);
    end
    reg_rd(8'h20, d);
    check("R1 R8 ctrl reset", d, 32'h0000_000F);
    reg_rd(8'h24, d);
    check("R1 node id reset", d, 32'h0);
    check("R9 req gate at reset", {31'b0, req_en}, 32'h0);
  endtask

  task automatic t_disabled_default;
    logic [5:0] r;
    for (int c = 0; c < 4; c++) begin
      lookup(3'd6, 2'(c), r);
      check("R7 default link while disabled", {26'b0, r}, {26'b0, 6'b10_0001});
    end
  endtask

  task automatic t_program;
    logic [31:0] d;
    reg_wr(8'h14, 32'hFFFA_F3F6);
    reg_rd(8'h14, d);
    check("R2 entry field packing", d, 32'h000A_0306);
    reg_wr(8'h17, 32'h0000_0000);
    reg_rd(8'h14, d);
    check("R2 addr low bits ignored", d, 32'h0);
    reg_wr(8'h14, 32'h000A_0306);
    reg_wr(8'h20, 32'hFFFF_FFF0);
    reg_rd(8'h20, d);
    check("R8 default link read-only", d, 32'h0000_000C);
    check("R9 req gate enabled", {31'b0, req_en}, 32'h1);
    reg_wr(8'h20, 32'h0000_0002);
    check("R9 req gate disabled", {31'b0, req_en}, 32'h0);
    reg_wr(8'h20, 32'h0);
  endtask

  task automatic t_classes;
    logic [5:0] r;
    lookup(3'd5, 2'd0, r);
    check("R3 request mask", {26'b0, r}, {26'b0, 6'b10_0110});
    lookup(3'd5, 2'd1, r);
    check("R3 response mask", {26'b0, r}, {26'b0, 6'b10_0011});
    lookup(3'd5, 2'd2, r);
    check("R3 broadcast multi-hot", {26'b0, r}, {26'b0, 6'b10_1010});
    lookup(3'd5, 2'd3, r);
    check("R4 reserved class zero", {26'b0, r}, {26'b0, 6'b10_0000});
    lookup(3'd3, 2'd0, r);
    check("R3 untouched entry", {26'b0, r}, {26'b0, 6'b10_0001});
    @(negedge clk);
    check("R5 idle outputs", {29'b0, lk_vo, lk_self, |lk_mask}, 32'h0);
  endtask

  task automatic t_write_order;
    logic [5:0] r;
    @(negedge clk);
    we = 1'b1; addr = 8'h08; wdata = 32'h0000_0008;
    lk_v = 1'b1; lk_dest = 3'd2; lk_cls = 2'd0;
    @(negedge clk);
    we = 1'b0;
    check("R6 same-cycle lookup sees old", {28'b0, lk_mask}, 32'h1);
    lk_v = 1'b1;
    @(negedge clk);
    lk_v = 1'b0;
    r = {lk_vo, lk_self, lk_mask};
    check("R6 next-cycle lookup sees new", {26'b0, r}, {26'b0, 6'b10_1000});
  endtask

  task automatic t_redisable;
    logic [5:0] r;
    reg_wr(8'h20, 32'h1);
    lookup(3'd5, 2'd2, r);
    check("R7 table bypassed", {26'b0, r}, {26'b0, 6'b10_0001});
    reg_wr(8'h20, 32'h0);
  endtask

  task automatic t_node_id;
    logic [31:0] d;
    logic [5:0]  r;
    reg_wr(8'h24, 32'hFFFF_FFFD);
    reg_rd(8'h24, d);
    check("R10 node id width", d, 32'h5);
    lookup(3'd5, 2'd0, r);
    check("R10 self flag hit", {31'b0, r[4]}, 32'h1);
    lookup(3'd4, 2'd0, r);
    check("R10 self flag miss", {31'b0, r[4]}, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    reg_wr(8'h28, 32'hFFFF_FFFF);
    reg_wr(8'hFC, 32'hFFFF_FFFF);
    reg_rd(8'h28, d);
    check("R11 unmapped reads zero", d, 32'h0);
    reg_rd(8'h20, d);
    check("R11 ctrl untouched", d, 32'h0000_000C);
    reg_rd(8'h24, d);
    check("R11 node id untouched", d, 32'h5);
    reg_rd(8'h14, d);
    check("R11 entry untouched", d, 32'h000A_0306);
  endtask

  initial begin
    #(20 * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled_default();
    t_program();
    t_classes();
    t_write_order();
    t_redisable();
    t_node_id();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule